// File: doc/BRIEF.md
# RTC Calendar Alarm Comparator

This block watches the running time and date of a real-time clock and raises an alarm when a programmed calendar moment arrives. Six alarm bytes (seconds, minutes, hours, date, month, day of week) hold BCD values in the same layout as the time fields. The top bit of each byte says whether that field takes part in the comparison. There is no year field. The clock supplies its current fields together with a one-cycle `tick` each time it updates them, and the comparison is made only on that tick.

Two alarm styles are offered. In the latched style a match sets the sticky `alm` flag and holds `irq_n` low until software clears the flag. The flag is cleared either by a status write or, when auto-clear is on, by a status read. In the repeating style every new match sets `alm` and drives `irq_n` low for a fixed number of clock cycles. The interrupt line is shared with a frequency output, and it is released high whenever `freq_sel` hands the pin to that function.

Top module: `rtc_alarm_match`

## Requirements
- R1: Write addresses 0 to 5 hold the alarm bytes for seconds, minutes, hours, date, month and day of week, in that order. In each byte, bit 7 enables the field and bits 6:0 are compared with bits 6:0 of the matching time input. Address 6 is control: bit 0 selects repeating mode and bit 1 enables auto-clear.
- R2: On a cycle with `tick` high, the alarm fires when every enabled field equals its time field, whatever values the disabled fields hold. `alm` reads 1 from the clock edge that samples that tick.
- R3: When all six enable bits are 0, no tick ever sets `alm`.
- R4: A fire happens only on the tick where the match begins. Later ticks on which the match still holds do not fire again, even after `alm` has been cleared.
- R5: In latched mode (control bit 0 = 0), `irq_n` is low exactly while `alm` is 1.
- R6: A write to address 7 with bit 0 = 0 clears `alm`. A write there with bit 0 = 1 has no effect.
- R7: With control bit 1 = 1, a `stat_rd` pulse clears `alm`. With control bit 1 = 0, `stat_rd` has no effect.
- R8: In repeating mode (control bit 0 = 1), each fire sets `alm` and drives `irq_n` low for exactly PULSE_W cycles, starting at the edge that samples the tick. Every new match fires again.
- R9: While `freq_sel` is 1, `irq_n` stays high. The `alm` flag behaves as usual.
- R10: A clear (status write or auto-clear read) that arrives in the same cycle as a fire loses, and `alm` stays 1.
- R11: After reset, all alarm bytes and control bits are 0, `alm` is 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe marking updated time fields |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current date, BCD |
| cur_month | input | 8 | Current month, BCD |
| cur_wday | input | 8 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe |
| freq_sel | input | 1 | 1 gives the interrupt pin to the frequency output |
| alm | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Each result appears at the clock edge that samples its stimulus. A tick or a write driven before an edge shows its effect on `alm` and `irq_n` right after that edge. The bench drives inputs on falling edges and samples on the following falling edge, half a cycle after the register has updated. The repeating-mode pulse is measured by counting the falling edges on which `irq_n` is low, starting with the one that follows the firing tick. That count must equal PULSE_W.

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int PULSE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_date,
  input  logic [7:0] cur_month,
  input  logic [7:0] cur_wday,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       stat_rd,
  input  logic       freq_sel,
  output logic       alm,
  output logic       irq_n
);
  localparam int NF = 6;
  localparam int CW = $clog2(PULSE_W + 1);

  logic [7:0]    abyte [NF];
  logic [7:0]    cur   [NF];
  logic [NF-1:0] en_mask;
  logic          rep_mode, arst, prev_match, match, hit, clr;
  logic [CW-1:0] pcnt;

  assign cur[0] = cur_sec;
  assign cur[1] = cur_min;
  assign cur[2] = cur_hour;
  assign cur[3] = cur_date;
  assign cur[4] = cur_month;
  assign cur[5] = cur_wday;

  always_comb begin
    logic all_ok;
    all_ok = 1'b1;
    for (int i = 0; i < NF; i++) begin
      en_mask[i] = abyte[i][7];
      if (abyte[i][7] && abyte[i][6:0] != cur[i][6:0]) all_ok = 1'b0;
    end
    match = all_ok && (en_mask != '0);
  end

  assign hit = tick && match && !prev_match;
  assign clr = (wr_en && wr_addr == 3'd7 && !wr_data[0]) || (stat_rd && arst);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) abyte[i] <= '0;
      rep_mode   <= 1'b0;
      arst       <= 1'b0;
      prev_match <= 1'b0;
      alm        <= 1'b0;
      pcnt       <= '0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (wr_en && wr_addr == 3'(i)) abyte[i] <= wr_data;
      if (wr_en && wr_addr == 3'd6) begin
        rep_mode <= wr_data[0];
        arst     <= wr_data[1];
      end
      if (tick) prev_match <= match;
      if (hit)      alm <= 1'b1;
      else if (clr) alm <= 1'b0;
      if (hit && rep_mode)  pcnt <= CW'(PULSE_W);
      else if (pcnt != '0)  pcnt <= pcnt - 1'b1;
    end
  end

  assign irq_n = freq_sel ? 1'b1 : (rep_mode ? (pcnt == '0) : !alm);
endmodule

module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       stat_rd,
  input logic       freq_sel,
  input logic       alm,
  input logic       irq_n,
  input logic       arst,
  input logic [5:0] en_mask
);
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alm) |-> $past(tick)); // R2
  AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0 && !alm) |=> !alm); // R3
  AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd7 && !wr_data[0] && !tick) |=> !alm); // R6
  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && arst && !tick) |=> !alm); // R7
  AST_FREQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    freq_sel |-> irq_n); // R9
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .stat_rd(stat_rd), .freq_sel(freq_sel), .alm(alm),
  .irq_n(irq_n), .arst(arst), .en_mask(en_mask)
);

// File: tb/tb_rtc_alarm_match.sv
module tb_rtc_alarm_match;
  localparam int PW = 4;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, stat_rd = 0, freq_sel = 0;
  logic [7:0] cs = 0, cm = 0, ch = 0, cd = 0, cmo = 0, cw = 0, wr_data = 0;
  logic [2:0] wr_addr = 0;
  logic alm, irq_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  rtc_alarm_match #(.PULSE_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_sec(cs), .cur_min(cm),
    .cur_hour(ch), .cur_date(cd), .cur_month(cmo), .cur_wday(cw),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .stat_rd(stat_rd),
    .freq_sel(freq_sel), .alm(alm), .irq_n(irq_n));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tk(logic [7:0] h, logic [7:0] m, logic [7:0] s,
                    logic [7:0] d, logic [7:0] mo, logic [7:0] w);
    ch = h; cm = m; cs = s; cd = d; cmo = mo; cw = w; tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic setup(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                       logic [7:0] d, logic [7:0] mo, logic [7:0] w, logic [7:0] c);
    wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo); wr(5, w); wr(6, c);
    wr(7, 8'h00);
  endtask

  task automatic t_reset;
    chk("R11 alm after reset", alm, 1'b0);
    chk("R11 irq_n after reset", irq_n, 1'b1);
  endtask

  task automatic t_no_enable;
    tk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R3 all disabled, zero time", alm, 1'b0);
    setup(8'h30, 8'h30, 8'h11, 8'h01, 8'h01, 8'h02, 8'h00);
    tk(8'h11, 8'h30, 8'h30, 8'h01, 8'h01, 8'h02);
    chk("R3 values equal but disabled", alm, 1'b0);
  endtask

  task automatic t_calendar;
    setup(8'h00, 8'hB0, 8'h91, 8'h81, 8'h81, 8'h00, 8'h00);
    tk(8'h11, 8'h29, 8'h59, 8'h01, 8'h01, 8'h04);
    chk("R2 one minute early", alm, 1'b0);
    tk(8'h11, 8'h30, 8'h00, 8'h01, 8'h01, 8'h04);
    chk("R1 R2 calendar match", alm, 1'b1);
    chk("R5 irq_n low while alm", irq_n, 1'b0);
    repeat (3) @(negedge clk);
    chk("R5 irq_n still low", irq_n, 1'b0);
    wr(7, 8'h01);
    chk("R6 write of 1 ignored", alm, 1'b1);
    wr(7, 8'h00);
    chk("R6 write clear", alm, 1'b0);
    chk("R5 irq_n released", irq_n, 1'b1);
    tk(8'h11, 8'h30, 8'h01, 8'h01, 8'h01, 8'h05);
    chk("R4 persisting match no refire", alm, 1'b0);
    tk(8'h11, 8'h30, 8'h01, 8'h02, 8'h01, 8'h05);
    chk("R2 date differs", alm, 1'b0);
    tk(8'h11, 8'h30, 8'h02, 8'h01, 8'h01, 8'h05);
    chk("R4 match begins again", alm, 1'b1);
    wr(7, 8'h00);
  endtask

  task automatic t_autoclear;
    setup(8'h85, 8'h00, 8'h00, 8'h00, 8'h00, 8'h83, 8'h00);
    tk(8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h04);
    chk("R1 day of week differs", alm, 1'b0);
    tk(8'h00, 8'h00, 8'h05, 8'h00, 8'h00, 8'h83);
    chk("R1 bit7 of time ignored", alm, 1'b1);
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk("R7 read without auto-clear", alm, 1'b1);
    wr(6, 8'h02);
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    chk("R7 auto-clear read", alm, 1'b0);
  endtask

  task automatic t_collision;
    setup(8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02);
    tk(8'h00, 8'h00, 8'h09, 8'h00, 8'h00, 8'h00);
    wr_en = 1; wr_addr = 7; wr_data = 0; stat_rd = 1;
    tk(8'h00, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00);
    wr_en = 0; stat_rd = 0;
    chk("R10 fire beats clear", alm, 1'b1);
    wr(7, 8'h00);
  endtask

  task automatic t_pulse;
    int low;
    setup(8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01);
    tk(8'h00, 8'h12, 8'h29, 8'h00, 8'h00, 8'h00);
    chk("R8 idle irq_n", irq_n, 1'b1);
    for (int rep = 0; rep < 2; rep++) begin
      tk(8'h00, 8'h12, 8'h30, 8'h00, 8'h00, 8'h00);
      chk("R8 alm set on pulse", alm, 1'b1);
      low = 0;
      for (int i = 0; i < 20; i++) begin
        if (!irq_n) low++;
        @(negedge clk);
      end
      checks++;
      if (low != PW) begin
        errors++;
        $display("FAIL R8 pulse width: got %0d expected %0d", low, PW);
      end
      chk("R8 alm still set after pulse", alm, 1'b1);
      wr(7, 8'h00);
      tk(8'h00, 8'h13, 8'h31, 8'h00, 8'h00, 8'h00);
    end
  endtask

  task automatic t_freq;
    setup(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h86, 8'h00);
    freq_sel = 1;
    tk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h06);
    chk("R9 alm still set", alm, 1'b1);
    chk("R9 irq_n held high", irq_n, 1'b1);
    freq_sel = 0;
    #1 chk("R9 irq_n after release", irq_n, 1'b0);
    wr(7, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_no_enable();
        t_calendar();
        t_autoclear();
        t_collision();
        t_pulse();
        t_freq();
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule